// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block folds a wide bank of general-purpose input pins (four ports of 32, 128 pins in total) onto eight interrupt channels. It is meant for a chip where every pin should be able to raise an interrupt, but the interrupt fabric cannot afford one line per pin. Each channel owns a fixed group of sixteen pins: those whose index within their port, taken modulo eight, equals the channel number. A 4-bit selector per channel picks which member of that group the channel watches.

Every pin is first brought into the clock domain by a two-flop synchroniser. Each channel then applies its own trigger rule to the selected pin. The rule can be a live level (high or low), a constant request, or a rising, falling or either-edge detector. Edge events are held in a sticky pending bit until software acknowledges them. A per-channel enable mask gates the pending bits onto a single interrupt output. Software reaches the trigger modes, the pin selectors, the enables, the acknowledge strobe and both status views through a word-wide register port with single-cycle writes and combinational reads.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset, the mode register (byte offset 120), the selector register (offset 124) and the enable register (offset 128) all read 0, raw status reads 0 and `irq_o` is low.
- R2: The mode register keeps 24 bits, the selector register keeps 32 bits and the enable register keeps bits [7:0]; each reads back what was written. The acknowledge offset (132) and every unmapped offset read 0.
- R3: Channel k takes its pin from selector bits [4k+3:4k]. A value s selects the global pin 8*s+k, which is port s[3:2], in-port index 8*s[1:0]+k. The other pins of the group have no effect on the channel.
- R4: Mode field bits [3k+2:3k] set the rule for channel k. In mode 1 the pending bit equals the selected pin's level, and in mode 2 it equals the inverse of that level. An acknowledge does not clear either of these.
- R5: Mode 3 makes the channel pending at all times. Modes 0 and 4 never make it pending.
- R6: Mode 5 latches a pending bit on a rising edge of the selected pin, mode 6 on a falling edge and mode 7 on either edge. The bit stays set after the pin returns to its earlier level.
- R7: A write to offset 132 clears the latched edge pending bit of every channel k whose data bit k is 1. Channels whose data bit is 0 keep their state.
- R8: If an acknowledge and a new qualifying edge on the same channel fall in the same cycle, the pending bit stays set.
- R9: Offset 136 returns the raw pending bits in [7:0]. Offset 140 returns the raw pending bits ANDed with the enable register.
- R10: `irq_o` is high exactly when the masked status at offset 140 is nonzero.
- R11: Any change to a channel's selector or mode field clears its latched edge pending bit. Comparing the old pin with the newly selected pin never reports an edge.
- R12: A level change on a pin reaches the raw status after two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 128 | Pin levels, port p bit g at index 32*p+g |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Assertions run on every cycle. They check that a latched edge bit holds until an acknowledge or a change of the channel's settings, and that an acknowledge with no new edge clears it. They also check that a coincident edge beats the acknowledge, that a settings change clears the bit, that the off modes never request, that acknowledge pulses come only from writes to their offset, and that enable writes land. The pin-to-channel mapping, the decoy pins of the same group, the two-edge synchroniser latency, the suppression of the false edge after reselection, and the masking onto `irq_o` all depend on scripted pin activity. Only the bench scenarios show those.

// File: rtl/gic_pkg.sv
package gic_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_ON   = 3'd3,
        TRIG_RSV  = 3'd4,
        TRIG_RISE = 3'd5,
        TRIG_FALL = 3'd6,
        TRIG_BOTH = 3'd7
    } trig_mode_e;

    localparam int MODE_W   = 3;
    localparam int OFF_MODE = 120;
    localparam int OFF_SEL  = 124;
    localparam int OFF_EN   = 128;
    localparam int OFF_ACK  = 132;
    localparam int OFF_RAW  = 136;
    localparam int OFF_MSK  = 140;

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o = st_q.s2;

endmodule

// File: rtl/gic_channel.sv
module gic_channel
    import gic_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH    = 0,
    parameter int SEL_W = 4,
    localparam int NSEL  = 1 << SEL_W,
    localparam int NPINS = NSEL * NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              ack_i,
    output logic              raw_o
);

    typedef struct packed {
        logic              prev;
        logic              pend;
        logic [SEL_W-1:0]  sel_last;
        logic [MODE_W-1:0] mode_last;
    } ch_t;

    ch_t st_d, st_q;

    logic [NSEL-1:0] grp;
    logic            cur;
    logic            cfg_chg;
    logic            hit;

    for (genvar s = 0; s < NSEL; s++) begin : g_grp
        assign grp[s] = pins_i[s*NCH + CH];
    end

    always_comb begin
        cur     = grp[sel_i];
        cfg_chg = (sel_i != st_q.sel_last) || (mode_i != st_q.mode_last);
        case (trig_mode_e'(mode_i))
            TRIG_RISE: hit = cur & ~st_q.prev;
            TRIG_FALL: hit = ~cur & st_q.prev;
            TRIG_BOTH: hit = cur ^ st_q.prev;
            default:   hit = 1'b0;
        endcase

        st_d           = st_q;
        st_d.prev      = cur;
        st_d.sel_last  = sel_i;
        st_d.mode_last = mode_i;
        if (cfg_chg) st_d.pend = 1'b0;
        else         st_d.pend = hit | (st_q.pend & ~ack_i);

        case (trig_mode_e'(mode_i))
            TRIG_HIGH: raw_o = cur;
            TRIG_LOW:  raw_o = ~cur;
            TRIG_ON:   raw_o = 1'b1;
            TRIG_RISE, TRIG_FALL, TRIG_BOTH: raw_o = st_q.pend;
            default:   raw_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: sticky while no ack and no settings change
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend && !ack_i && !cfg_chg |=> st_q.pend);

    // R7: ack without a new edge clears
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && !hit |=> !st_q.pend);

    // R8: a coincident edge wins over the ack
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !cfg_chg |=> st_q.pend);

    // R11: a settings change drops the latched bit
    a_r11_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !st_q.pend);

    // R5: off modes never request
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 || mode_i == 3'd4) |-> !raw_o);

endmodule

// File: rtl/gic_regs.sv
module gic_regs
    import gic_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SEL_W = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int CFG_W = NCH * MODE_W,
    localparam int SSW   = NCH * SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [NCH-1:0]   raw_i,
    output logic [CFG_W-1:0] mode_o,
    output logic [SSW-1:0]   sel_o,
    output logic [NCH-1:0]   en_o,
    output logic [NCH-1:0]   ack_o,
    output logic [DW-1:0]    rdata_o
);

    typedef struct packed {
        logic [CFG_W-1:0] mode;
        logic [SSW-1:0]   sel;
        logic [NCH-1:0]   en;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (addr_i == AW'(OFF_MODE)) st_d.mode = wdata_i[CFG_W-1:0];
            if (addr_i == AW'(OFF_SEL))  st_d.sel  = wdata_i[SSW-1:0];
            if (addr_i == AW'(OFF_EN))   st_d.en   = wdata_i[NCH-1:0];
        end
        ack_o = (wr_i && addr_i == AW'(OFF_ACK)) ? wdata_i[NCH-1:0] : '0;

        case (addr_i)
            AW'(OFF_MODE): rdata_o = DW'(st_q.mode);
            AW'(OFF_SEL):  rdata_o = DW'(st_q.sel);
            AW'(OFF_EN):   rdata_o = DW'(st_q.en);
            AW'(OFF_RAW):  rdata_o = DW'(raw_i);
            AW'(OFF_MSK):  rdata_o = DW'(raw_i & st_q.en);
            default:       rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign sel_o  = st_q.sel;
    assign en_o   = st_q.en;

    // R7: ack strobes only come from writes to the ack offset
    a_r7_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (wr_i && addr_i == AW'(OFF_ACK)));

    // R2: enable writes land in the next cycle
    a_r2_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && addr_i == AW'(OFF_EN) |=> en_o == $past(wdata_i[NCH-1:0]));

endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
    import gic_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SEL_W = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int NPINS = (1 << SEL_W) * NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] gpio_i,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_o
);

    logic [NPINS-1:0]        sync_w;
    logic [NCH*MODE_W-1:0]   mode_w;
    logic [NCH*SEL_W-1:0]    sel_w;
    logic [NCH-1:0]          en_w;
    logic [NCH-1:0]          ack_w;
    logic [NCH-1:0]          raw_w;

    gic_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (gpio_i),
        .dout_o (sync_w)
    );

    gic_regs #(.NCH(NCH), .SEL_W(SEL_W), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .raw_i   (raw_w),
        .mode_o  (mode_w),
        .sel_o   (sel_w),
        .en_o    (en_w),
        .ack_o   (ack_w),
        .rdata_o (bus_rdata)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        gic_channel #(.NCH(NCH), .CH(k), .SEL_W(SEL_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins_i (sync_w),
            .sel_i  (sel_w[k*SEL_W +: SEL_W]),
            .mode_i (mode_w[k*MODE_W +: MODE_W]),
            .ack_i  (ack_w[k]),
            .raw_o  (raw_w[k])
        );
    end

    assign irq_o = |(raw_w & en_w);

    // R10: a rising request needs an enabled channel
    a_r10_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (|en_w));

endmodule

// File: tb/tb_gpio_grp_irq.sv
`timescale 1ns/1ps
module tb_gpio_grp_irq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] gpio = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_grp_irq dut (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    localparam logic [7:0] A_MODE = 8'd120, A_SEL = 8'd124, A_EN = 8'd128,
                           A_ACK = 8'd132, A_RAW = 8'd136, A_MSK = 8'd140;

    // {expect, decoy, level, mode[2:0], sel[3:0], ch[2:0]}
    localparam logic [12:0] VEC [0:9] = '{
        {1'b1, 1'b0, 1'b1, 3'd1, 4'd0,  3'd0},
        {1'b0, 1'b0, 1'b0, 3'd1, 4'd0,  3'd0},
        {1'b1, 1'b0, 1'b0, 3'd2, 4'd5,  3'd3},
        {1'b0, 1'b0, 1'b1, 3'd2, 4'd5,  3'd3},
        {1'b1, 1'b0, 1'b1, 3'd1, 4'd15, 3'd7},
        {1'b0, 1'b1, 1'b1, 3'd1, 4'd10, 3'd5},
        {1'b1, 1'b0, 1'b0, 3'd3, 4'd7,  3'd2},
        {1'b0, 1'b0, 1'b1, 3'd0, 4'd3,  3'd6},
        {1'b0, 1'b0, 1'b1, 3'd4, 4'd12, 3'd1},
        {1'b1, 1'b1, 1'b0, 3'd2, 4'd9,  3'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        br(A_MODE, r); chk("R1 mode reset", r, 32'h0);
        br(A_SEL, r);  chk("R1 sel reset", r, 32'h0);
        br(A_EN, r);   chk("R1 enable reset", r, 32'h0);
        br(A_RAW, r);  chk("R1 raw reset", r, 32'h0);
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);

        // R2 register readback
        bw(A_MODE, 32'hFFFAC688); br(A_MODE, r); chk("R2 mode readback", r, 32'h00FAC688);
        bw(A_SEL, 32'hDEADBEEF);  br(A_SEL, r);  chk("R2 sel readback", r, 32'hDEADBEEF);
        bw(A_EN, 32'h000001A5);   br(A_EN, r);   chk("R2 enable readback", r, 32'h000000A5);
        br(A_ACK, r);  chk("R2 ack reads zero", r, 32'h0);
        br(8'h00, r);  chk("R2 unmapped reads zero", r, 32'h0);
        br(8'h8E, r);  chk("R2 unmapped reads zero", r, 32'h0);
        bw(A_MODE, 0); bw(A_SEL, 0); bw(A_EN, 0);

        // R3 R4 R5 vector table
        for (int i = 0; i < 10; i++) begin
            logic [12:0] v;
            int ch, sel, pin;
            v = VEC[i];
            ch = int'(v[2:0]); sel = int'(v[6:3]);
            gpio = '0;
            bw(A_MODE, 0);
            bw(A_SEL, 32'(v[6:3]) << (4*ch));
            bw(A_MODE, 32'(v[9:7]) << (3*ch));
            pin = v[11] ? 8*(sel ^ 1) + ch : 8*sel + ch;
            gpio[pin] = v[10];
            idle(4);
            br(A_RAW, r);
            chk($sformatf("R3 R4 R5 vector %0d", i), r, 32'(v[12]) << ch);
        end
        gpio = '0; bw(A_MODE, 0); bw(A_SEL, 0); idle(3);

        // R4 level not cleared by ack
        bw(A_MODE, 32'd1); gpio[0] = 1'b1; idle(4);
        bw(A_ACK, 32'hFF); br(A_RAW, r); chk("R4 level survives ack", r, 32'h1);

        // R12 synchroniser latency, channel 0 level high, pin 0
        gpio[0] = 1'b0; idle(4);
        @(negedge clk); bus_addr = A_RAW; gpio[0] = 1'b1;
        @(negedge clk); #1 chk("R12 after one edge", {31'b0, bus_rdata[0]}, 32'h0);
        @(negedge clk); #1 chk("R12 after two edges", {31'b0, bus_rdata[0]}, 32'h1);
        gpio[0] = 1'b0; bw(A_MODE, 0); idle(3);

        // R6 rising on channel 1 (pin 1), falling on channel 2 (pin 2)
        bw(A_MODE, (32'd5 << 3) | (32'd6 << 6)); idle(2);
        gpio[1] = 1'b1; gpio[2] = 1'b1; idle(4);
        br(A_RAW, r); chk("R6 rise latched, fall idle", r, 32'h02);
        gpio[1] = 1'b0; gpio[2] = 1'b0; idle(4);
        br(A_RAW, r); chk("R6 sticky and fall latched", r, 32'h06);

        // R9 R10 masking with channels 1 and 2 pending
        br(A_MSK, r); chk("R9 masked with enables off", r, 32'h0);
        chk("R10 irq low with enables off", {31'b0, irq_o}, 32'h0);
        bw(A_EN, 32'h02); br(A_MSK, r); chk("R9 masked channel 1", r, 32'h02);
        chk("R10 irq high", {31'b0, irq_o}, 32'h1);
        bw(A_EN, 32'hF9); br(A_MSK, r); chk("R9 masked others", r, 32'h0);
        chk("R10 irq low again", {31'b0, irq_o}, 32'h0);

        // R7 ack with zero bits, then selective ack
        bw(A_ACK, 32'hF9); br(A_RAW, r); chk("R7 zero bits keep state", r, 32'h06);
        bw(A_ACK, 32'h02); br(A_RAW, r); chk("R7 ack clears channel 1 only", r, 32'h04);
        bw(A_ACK, 32'h04); br(A_RAW, r); chk("R7 ack clears channel 2", r, 32'h0);
        bw(A_MODE, 0); bw(A_EN, 0); idle(2);

        // R8 ack coincides with new edge on channel 3 (pin 3, either edge)
        bw(A_MODE, 32'd7 << 9); idle(2);
        gpio[3] = 1'b1; idle(4);
        br(A_RAW, r); chk("R6 either edge latched", r, 32'h08);
        gpio[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h08;
        @(negedge clk);
        bus_wr = 1'b0;
        br(A_RAW, r); chk("R8 edge wins over ack", r, 32'h08);
        bw(A_ACK, 32'h08); br(A_RAW, r); chk("R7 plain ack clears", r, 32'h0);
        bw(A_MODE, 0); idle(2);

        // R11 reselection clears and reports no false edge
        bw(A_MODE, 32'd7); idle(2);
        gpio[0] = 1'b1; idle(4);
        br(A_RAW, r); chk("R11 setup edge latched", r, 32'h01);
        bw(A_SEL, 32'd1); idle(4);
        br(A_RAW, r); chk("R11 reselect clears, no false edge", r, 32'h0);
        gpio[8] = 1'b1; idle(4);
        br(A_RAW, r); chk("R3 R11 new pin 8 watched", r, 32'h01);
        bw(A_MODE, 32'd6); idle(3);
        br(A_RAW, r); chk("R11 mode change clears", r, 32'h0);

        finish_run();
    end

endmodule